// File: doc/BRIEF.md
# ADC Command-Channel Register and Interrupt Unit

This block is the word-addressed register front end that sits between a simple single-cycle register bus and an external converter command engine. It keeps four writable registers: configuration, interrupt status, interrupt mask and channel control. It builds a read-only FIFO status word from the response level that the engine reports. Writes to the command window go to the engine as a push strobe. Reads of the response window return the engine's head word and send it a pop strobe.

The interrupt status bits are sticky. Hardware events set them, and software clears them by writing 1 to each bit. The data-threshold bit is set while the response level is above a programmable threshold. The command-low bit is set again after every bus access, because the command path never queues anything. A single level-sensitive interrupt output is the OR of all status bits whose mask bit is 0.

An access is a single cycle with `bus_sel` high. Read data and strobes are combinational in that cycle. Register updates take effect at the closing clock edge.

Top module: `adc_regif`

## Requirements
- R1: After reset the registers read as follows: configuration 0x00001814, interrupt status 0x00000200, mask 0xFFFFFFFF and control 0x00000010. `irq` is 0 and `chan_rst` is 1.
- R2: The configuration register (byte offset 0x00) stores all 32 written bits. A write to the control register (offset 0x18) stores the written value ANDed with 0x00FFFEFF. `chan_rst` follows control bit 4.
- R3: A write to the mask register (offset 0x08) stores only bits 9:0 and clears bits 31:10.
- R4: The interrupt status register (offset 0x04) has these bits: 9 command-low, 8 response-above-threshold, 7 over-temperature (`ot_evt`) and 6:0 alarms (`alm_evt`). An event input sets its bit and the bit stays set. Writing 1 to a bit clears it. If a set and a clear happen in the same cycle, the set wins.
- R5: Status bit 8 is set on every cycle in which `rsp_level` is strictly greater than configuration bits 19:16. The bit stays set after the condition goes away.
- R6: Status bit 9 is set by every bus access, including a write that clears it.
- R7: `irq` is high exactly when some status bit has a mask bit of 0. It changes in the cycle after the register change that causes it.
- R8: A read of offset 0x0C returns a status word with these fields: `rsp_level` in bits 15:12, command-empty at bit 10 (always 1), response-full at bit 9 (level equals FIFO_DEPTH) and response-empty at bit 8 (level 0). All other bits read 0.
- R9: A write to offset 0x10 raises `cmd_push` for that one cycle, with `cmd_data` equal to the written word. No push is issued while `chan_rst` is 1.
- R10: A read of offset 0x14 returns `rsp_data` zero-extended in the same cycle and raises `rsp_pop` for exactly that cycle.
- R11: The following accesses change no state, raise no strobe, and read as 0: a read of 0x10, a write to 0x0C or 0x14, any access to an unmapped offset, and any access to an address that is not word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ot_evt | input | 1 | Over-temperature event |
| alm_evt | input | 7 | Alarm events |
| cmd_push | output | 1 | Command push strobe |
| cmd_data | output | 32 | Command word |
| rsp_pop | output | 1 | Response pop strobe |
| rsp_data | input | 16 | Response head word |
| rsp_level | input | LVL_W | Response FIFO fill level |
| cfg_out | output | 32 | Current configuration register |
| chan_rst | output | 1 | Command channel held in reset |
| irq | output | 1 | Level interrupt |

## Verification
Read data and both strobes are due in the access cycle itself. The bench drives each access on a falling edge and samples 1 ns later, before the rising edge that ends the access. Register and status updates land at that rising edge, so they are checked by a read in the following cycle. `irq` is sampled on the falling edge after the updating rising edge. A change in response level is given one full cycle before the threshold bit is read.

// File: rtl/adc_regif.sv
module adc_regif #(
  parameter int ADDR_W     = 5,
  parameter int LVL_W      = 4,
  parameter int FIFO_DEPTH = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ot_evt,
  input  logic [6:0]        alm_evt,
  output logic              cmd_push,
  output logic [31:0]       cmd_data,
  output logic              rsp_pop,
  input  logic [15:0]       rsp_data,
  input  logic [LVL_W-1:0]  rsp_level,
  output logic [31:0]       cfg_out,
  output logic              chan_rst,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_CFG  = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_STS  = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_MSK  = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_FST  = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_CMD  = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_RSP  = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_CTL  = IDX_W'(6);
  localparam logic [31:0] CFG_RST  = 32'h0000_1814;
  localparam logic [31:0] CTL_RST  = 32'h0000_0010;
  localparam logic [31:0] CTL_KEEP = 32'h00FF_FEFF;

  logic [31:0] cfg_q, mask_q, ctrl_q;
  logic [9:0]  sts_q;

  logic [IDX_W-1:0] idx;
  logic aligned, rd_ok, wr_ok;
  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign rd_ok   = bus_sel && !bus_wr && aligned &&
                   (idx == I_CFG || idx == I_STS || idx == I_MSK ||
                    idx == I_FST || idx == I_RSP || idx == I_CTL);
  assign wr_ok   = bus_sel && bus_wr && aligned &&
                   (idx == I_CFG || idx == I_STS || idx == I_MSK ||
                    idx == I_CMD || idx == I_CTL);

  logic [9:0] sts_set, sts_clr;
  assign sts_set = {bus_sel, (rsp_level > cfg_q[16 +: LVL_W]), ot_evt, alm_evt};
  assign sts_clr = (wr_ok && idx == I_STS) ? bus_wdata[9:0] : 10'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      sts_q  <= 10'h200;
      mask_q <= '1;
      ctrl_q <= CTL_RST;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (wr_ok && idx == I_CFG) cfg_q  <= bus_wdata;
      if (wr_ok && idx == I_MSK) mask_q <= {22'd0, bus_wdata[9:0]};
      if (wr_ok && idx == I_CTL) ctrl_q <= bus_wdata & CTL_KEEP;
    end
  end

  logic [31:0] fifo_word;
  always_comb begin
    fifo_word = '0;
    fifo_word[12 +: LVL_W] = rsp_level;
    fifo_word[10] = 1'b1;
    fifo_word[9]  = (rsp_level == LVL_W'(FIFO_DEPTH));
    fifo_word[8]  = (rsp_level == '0);
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (idx)
        I_CFG:   bus_rdata = cfg_q;
        I_STS:   bus_rdata = {22'd0, sts_q};
        I_MSK:   bus_rdata = mask_q;
        I_FST:   bus_rdata = fifo_word;
        I_RSP:   bus_rdata = {16'd0, rsp_data};
        I_CTL:   bus_rdata = ctrl_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign chan_rst = ctrl_q[4];
  assign cmd_push = wr_ok && idx == I_CMD && !chan_rst;
  assign cmd_data = bus_wdata;
  assign rsp_pop  = rd_ok && idx == I_RSP;
  assign cfg_out  = cfg_q;
  assign irq      = |(sts_q & ~mask_q[9:0]);
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int ADDR_W = 5,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [LVL_W-1:0]  rsp_level,
  input logic [31:0]       cfg_q,
  input logic [9:0]        sts_q,
  input logic [31:0]       mask_q,
  input logic [31:0]       ctrl_q,
  input logic              ot_evt,
  input logic [6:0]        alm_evt,
  input logic              cmd_push,
  input logic              rsp_pop,
  input logic              chan_rst
);
  logic at_ctl, at_msk, at_sts, at_rsp, unmapped;
  assign at_ctl   = bus_addr == ADDR_W'(8'h18);
  assign at_msk   = bus_addr == ADDR_W'(8'h08);
  assign at_sts   = bus_addr == ADDR_W'(8'h04);
  assign at_rsp   = bus_addr == ADDR_W'(8'h14);
  assign unmapped = bus_addr[1:0] != 2'b00 || bus_addr == ADDR_W'(8'h1C);

  assert_ctrl_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && at_ctl |=> ctrl_q == ($past(bus_wdata) & 32'h00FF_FEFF));

  assert_mask_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && at_msk |=> mask_q == {22'd0, $past(bus_wdata[9:0])});

  assert_alarm_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && at_sts && bus_wdata[6:0] == 7'h7F && alm_evt == 7'd0
    |=> sts_q[6:0] == 7'd0);

  assert_thresh_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_level > cfg_q[16 +: LVL_W] |=> sts_q[8]);

  assert_access_bit9_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> sts_q[9]);

  assert_push_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> !chan_rst && bus_sel && bus_wr);

  assert_pop_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pop |-> bus_sel && !bus_wr && at_rsp);

  assert_bad_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && unmapped |-> bus_rdata == 32'd0 && !rsp_pop && !cmd_push);

  assert_ot_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ot_evt |=> sts_q[7]);
endmodule

bind adc_regif adc_regif_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rsp_level(rsp_level), .cfg_q(cfg_q), .sts_q(sts_q), .mask_q(mask_q),
  .ctrl_q(ctrl_q), .ot_evt(ot_evt), .alm_evt(alm_evt), .cmd_push(cmd_push),
  .rsp_pop(rsp_pop), .chan_rst(chan_rst)
);

// File: tb/test_adc_regif.sv
`timescale 1ns/1ps
module test_adc_regif;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cmd_data, cfg_out;
  logic ot_evt = 0;
  logic [6:0] alm_evt = '0;
  logic cmd_push, rsp_pop, chan_rst, irq;
  logic [15:0] rsp_data = '0;
  logic [3:0] rsp_level = '0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] cap_rd, cap_cmd;
  logic cap_push, cap_pop;

  always #2.5 clk = ~clk;

  adc_regif i_adc_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ot_evt(ot_evt), .alm_evt(alm_evt), .cmd_push(cmd_push),
    .cmd_data(cmd_data), .rsp_pop(rsp_pop), .rsp_data(rsp_data),
    .rsp_level(rsp_level), .cfg_out(cfg_out), .chan_rst(chan_rst), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    cap_rd = bus_rdata; cap_push = cmd_push; cap_pop = rsp_pop; cap_cmd = cmd_data;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    #1;
  endtask

  task automatic rd(input logic [4:0] a); access(0, a, 32'd0); endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d); access(1, a, d); endtask

  task automatic t_reset;
    rd(5'h00); check("R1 cfg", cap_rd, 32'h0000_1814);
    rd(5'h04); check("R1 sts", cap_rd, 32'h0000_0200);
    rd(5'h08); check("R1 mask", cap_rd, 32'hFFFF_FFFF);
    rd(5'h18); check("R1 ctrl", cap_rd, 32'h0000_0010);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 chan_rst", {31'd0, chan_rst}, 32'd1);
  endtask

  task automatic t_cfg_ctrl;
    wr(5'h00, 32'hA5A5_0003); rd(5'h00); check("R2 cfg", cap_rd, 32'hA5A5_0003);
    check("R2 cfg_out", cfg_out, 32'hA5A5_0003);
    wr(5'h18, 32'hFFFF_FFFF); rd(5'h18); check("R2 ctrl and", cap_rd, 32'h00FF_FEFF);
    check("R2 chan_rst set", {31'd0, chan_rst}, 32'd1);
    wr(5'h18, 32'h0000_0000); check("R2 chan_rst clr", {31'd0, chan_rst}, 32'd0);
  endtask

  task automatic t_mask;
    wr(5'h08, 32'hFFFF_FD55); rd(5'h08); check("R3 mask bits", cap_rd, 32'h0000_0155);
    wr(5'h08, 32'h0); check("R7 irq bit9 unmasked", {31'd0, irq}, 32'd1);
    wr(5'h08, 32'h200);
  endtask

  task automatic t_sticky;
    @(negedge clk); ot_evt = 1; alm_evt = 7'h05;
    @(negedge clk); ot_evt = 0; alm_evt = 0;
    #1 check("R7 irq from alarm", {31'd0, irq}, 32'd1);
    rd(5'h04); check("R4 sticky set", cap_rd, 32'h0000_0285);
    wr(5'h04, 32'h084); rd(5'h04); check("R4 w1c partial", cap_rd, 32'h0000_0201);
    wr(5'h04, 32'h3FF); rd(5'h04); check("R6 bit9 after clear", cap_rd, 32'h0000_0200);
    check("R7 irq low", {31'd0, irq}, 32'd0);
    alm_evt = 7'h01; wr(5'h04, 32'h001); alm_evt = 0;
    rd(5'h04); check("R4 set wins", cap_rd, 32'h0000_0201);
    wr(5'h04, 32'h001);
  endtask

  task automatic t_thresh;
    wr(5'h00, 32'h0006_0000);
    rsp_level = 4'd6; @(negedge clk); @(negedge clk);
    rd(5'h04); check("R5 equal not set", cap_rd, 32'h0000_0200);
    rsp_level = 4'd7; @(negedge clk); @(negedge clk);
    rd(5'h04); check("R5 above set", cap_rd, 32'h0000_0300);
    check("R7 irq from thresh", {31'd0, irq}, 32'd1);
    rsp_level = 4'd0; @(negedge clk);
    rd(5'h04); check("R5 sticky", cap_rd, 32'h0000_0300);
    wr(5'h04, 32'h100); rd(5'h04); check("R5 cleared", cap_rd, 32'h0000_0200);
  endtask

  task automatic t_fifo_word;
    rsp_level = 4'd0; rd(5'h0C); check("R8 empty", cap_rd, 32'h0000_0500);
    rsp_level = 4'd3; rd(5'h0C); check("R8 mid", cap_rd, 32'h0000_3400);
    rsp_level = 4'd15; rd(5'h0C); check("R8 full", cap_rd, 32'h0000_F600);
    rsp_level = 4'd0;
  endtask

  task automatic t_cmd;
    wr(5'h10, 32'h0401_2345);
    check("R9 push", {31'd0, cap_push}, 32'd1);
    check("R9 data", cap_cmd, 32'h0401_2345);
    check("R9 one cycle", {31'd0, cmd_push}, 32'd0);
    wr(5'h18, 32'h10); wr(5'h10, 32'h0801_0000);
    check("R9 gated in reset", {31'd0, cap_push}, 32'd0);
    wr(5'h18, 32'h0);
  endtask

  task automatic t_rsp;
    rsp_data = 16'hBEEF; rd(5'h14);
    check("R10 data", cap_rd, 32'h0000_BEEF);
    check("R10 pop", {31'd0, cap_pop}, 32'd1);
    check("R10 pop one cycle", {31'd0, rsp_pop}, 32'd0);
  endtask

  task automatic t_bad;
    rd(5'h10); check("R11 read cmd", cap_rd, 32'd0);
    check("R11 no pop", {31'd0, cap_pop}, 32'd0);
    wr(5'h14, 32'hFFFF); check("R11 write rsp no strobe", {30'd0, cap_push, cap_pop}, 32'd0);
    rd(5'h1C); check("R11 unmapped", cap_rd, 32'd0);
    wr(5'h01, 32'h0); rd(5'h00); check("R11 misaligned", cap_rd, 32'h0006_0000);
    rd(5'h11); check("R11 misaligned rd", cap_rd, 32'd0);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h08); check("R11 write status word", cap_rd, 32'h200);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_cfg_ctrl; t_mask; t_sticky; t_thresh; t_fifo_word; t_cmd; t_rsp; t_bad;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule